// File: doc/BRIEF.md
# Trimmed One-Second Divider with Frequency-Test Tap

This block turns a 32,768 Hz oscillator enable into a one-second tick and trims the clock rate digitally. The prescaler has two stages. The lower stage divides by 256 and the upper stage divides by 128. A signed trim value is applied on a repeating 64-minute schedule. In each eligible minute, the first second is either shortened by one full lower-stage period or lengthened by half of one. The two directions therefore carry unequal weight: a speed-up step is worth twice a slow-down step.

The trim value is six bits wide: a five-bit magnitude N and a sign. A magnitude of N touches the first 2N minutes of the schedule, and never more than the first 62. The value is captured at the start of each minute, so writes from software take effect on a minute boundary. A separate 512 Hz square wave is divided from the same enable ahead of any trim, for measuring the crystal in production. Several enable conditions gate it. A stop input freezes the whole block.

Top module: `rtc_trim_divider`

## Requirements
- R1: While reset is low, and right after it is released, tick_1hz and ft_out are 0. The first second after release lasts a full nominal LOW_DIV*HIGH_DIV enables.
- R2: With magnitude 0, every second lasts exactly LOW_DIV*HIGH_DIV counted enables.
- R3: With cal_byte[5]=1 (speed up) and magnitude N = cal_byte[4:0], the first second of minute m is LOW_DIV enables shorter than nominal when m < 2N.
- R4: With cal_byte[5]=0 (slow down) and magnitude N, the first second of minute m is LOW_DIV/2 enables longer than nominal when m < 2N.
- R5: Seconds other than the first of a minute, and minutes m >= 2N, are never adjusted. Minutes are counted 0 to CYCLE_MIN-1 and then wrap to 0. With N=31, minutes 0 to 61 are adjusted and minutes 62 and 63 are not.
- R6: cal_byte is captured on the first counted enable of each minute. A change made later in a minute has no effect until the next minute.
- R7: While stop is 1, no enable is counted, no tick is produced and ft_out holds its level. After stop clears, the interrupted second continues from where it was held.
- R8: Only clock cycles with osc_en high advance the block. With osc_en high every other cycle, a nominal second spans twice as many clocks.
- R9: When stop=0, ft_en=1, alarm_flag_en=0 and either wdog_steer=1 or wdog_zero=1, ft_out toggles once every FT_HALF counted enables, starting from 0.
- R10: When stop=0 and the R9 condition does not hold, ft_out is 0 from the next cycle.
- R11: The trim value has no effect on the ft_out toggle spacing, including during an adjusted second.
- R12: tick_1hz is a single-cycle pulse, high in the cycle after the enable that completes a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| osc_en | input | 1 | One-cycle enable at the oscillator rate |
| stop | input | 1 | Freeze all counting and hold the test output |
| cal_byte | input | MAG_W+1 | Trim value: top bit is the sign (1 speeds up), lower bits are the magnitude |
| ft_en | input | 1 | Frequency-test enable |
| alarm_flag_en | input | 1 | Alarm flag output enable; blocks the test output when 1 |
| wdog_steer | input | 1 | Watchdog steering bit; 1 allows the test output |
| wdog_zero | input | 1 | Watchdog register is zero; 1 allows the test output |
| tick_1hz | output | 1 | One-cycle pulse per corrected second |
| ft_out | output | 1 | Untrimmed 512 Hz test square wave |

## Verification
The prescaler is run with a zero trim, with one-step and full-scale trims in each direction, and with a trim value rewritten in the middle of an adjusted minute. Comparing second lengths against the nominal count separates the shorten, lengthen and untouched cases. Checking the first second of minutes 61, 62, 63 and the wrapped minute 0 pins down both the 62-minute limit and the wrap of the cycle. A run with the enable on every other clock, and a stop window in the middle of a second, show that only counted enables move the divider. The test output is checked under each gating combination and with a full-scale trim, and its toggle spacing must stay the same across an adjusted second.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   // Kind of correction the scheduler requests for the current second.
   typedef enum logic [1:0] {
      TRIM_NONE = 2'd0,
      TRIM_FAST = 2'd1,
      TRIM_SLOW = 2'd2
   } trim_e;

endpackage

// File: rtl/trim_prescaler.sv
module trim_prescaler
   import rtc_trim_pkg::*;
#(
   parameter int LOW_DIV  = 256,
   parameter int HIGH_DIV = 128
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  step,
   input  trim_e trim,
   output logic  sec_end,
   output logic  at_zero
);
   localparam int LOW_LONG = LOW_DIV + LOW_DIV / 2;
   localparam int LOW_W    = $clog2(LOW_LONG);
   localparam int HIGH_W   = $clog2(HIGH_DIV);

   logic [LOW_W-1:0]  low_q;
   logic [HIGH_W-1:0] high_q;
   logic [LOW_W-1:0]  low_top;
   logic [HIGH_W-1:0] high_top;
   logic              low_end;
   logic              high_end;

   // The slow trim stretches only the first lower-stage period of the second.
   // The fast trim drops one upper-stage count.
   always_comb begin
      low_top  = ((trim == TRIM_SLOW) && (high_q == '0)) ? LOW_W'(LOW_LONG - 1)
                                                         : LOW_W'(LOW_DIV - 1);
      high_top = (trim == TRIM_FAST) ? HIGH_W'(HIGH_DIV - 2) : HIGH_W'(HIGH_DIV - 1);
      low_end  = (low_q == low_top);
      high_end = (high_q == high_top);
      sec_end  = step && low_end && high_end;
      at_zero  = (low_q == '0) && (high_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         high_q <= '0;
      end else if (step) begin
         if (low_end) begin
            low_q  <= '0;
            high_q <= high_end ? '0 : high_q + 1'b1;
         end else begin
            low_q  <= low_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/trim_scheduler.sv
module trim_scheduler
   import rtc_trim_pkg::*;
#(
   parameter int SEC_PER_MIN = 60,
   parameter int CYCLE_MIN   = 64,
   parameter int ADJ_MIN     = 62,
   parameter int MAG_W       = 5,
   localparam int MIN_W      = $clog2(CYCLE_MIN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             sec_end,
   input  logic             at_zero,
   input  logic [MAG_W:0]   cal_in,
   output trim_e            trim,
   output logic [MIN_W-1:0] min_cnt,
   output logic             minute_start,
   output logic [MAG_W:0]   cal_q
);
   localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

   logic [SEC_W-1:0] sec_q;
   logic [MIN_W-1:0] min_q;
   logic             eligible;

   assign min_cnt      = min_q;
   assign minute_start = step && at_zero && (sec_q == '0);

   always_comb begin
      eligible = (sec_q == '0)
              && (int'(min_q) < 2 * int'(cal_q[MAG_W-1:0]))
              && (int'(min_q) < ADJ_MIN);
      if (!eligible)         trim = TRIM_NONE;
      else if (cal_q[MAG_W]) trim = TRIM_FAST;
      else                   trim = TRIM_SLOW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
         min_q <= '0;
         cal_q <= '0;
      end else begin
         if (minute_start) cal_q <= cal_in;
         if (sec_end) begin
            if (sec_q == SEC_W'(SEC_PER_MIN - 1)) begin
               sec_q <= '0;
               min_q <= (min_q == MIN_W'(CYCLE_MIN - 1)) ? '0 : min_q + 1'b1;
            end else begin
               sec_q <= sec_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ft_divider.sv
module ft_divider #(
   parameter int FT_HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   input  logic stop,
   input  logic gate,
   output logic ft_out
);
   localparam int FT_W = $clog2(FT_HALF);

   logic [FT_W-1:0] cnt_q;
   logic            out_q;

   assign ft_out = out_q;

   // Stop freezes the divider; a closed gate parks it low and cleared.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (!stop) begin
         if (!gate) begin
            cnt_q <= '0;
            out_q <= 1'b0;
         end else if (osc_en) begin
            if (cnt_q == FT_W'(FT_HALF - 1)) begin
               cnt_q <= '0;
               out_q <= ~out_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
   import rtc_trim_pkg::*;
#(
   parameter int LOW_DIV     = 256,
   parameter int HIGH_DIV    = 128,
   parameter int SEC_PER_MIN = 60,
   parameter int CYCLE_MIN   = 64,
   parameter int ADJ_MIN     = 62,
   parameter int MAG_W       = 5,
   parameter int FT_HALF     = 32,
   parameter bit TICK_REG    = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           osc_en,
   input  logic           stop,
   input  logic [MAG_W:0] cal_byte,
   input  logic           ft_en,
   input  logic           alarm_flag_en,
   input  logic           wdog_steer,
   input  logic           wdog_zero,
   output logic           tick_1hz,
   output logic           ft_out
);
   localparam int MIN_W = $clog2(CYCLE_MIN);

   // Elaboration-time parameter checks.
   if (LOW_DIV < 2 || (LOW_DIV % 2) != 0) begin : g_bad_low
      $error("LOW_DIV must be even and at least 2");
   end
   if (HIGH_DIV < 2) begin : g_bad_high
      $error("HIGH_DIV must be at least 2");
   end
   if (FT_HALF < 2) begin : g_bad_ft
      $error("FT_HALF must be at least 2");
   end
   if (ADJ_MIN > CYCLE_MIN || CYCLE_MIN < 2) begin : g_bad_cycle
      $error("ADJ_MIN must not exceed CYCLE_MIN");
   end
   if (2 * ((1 << MAG_W) - 1) > ADJ_MIN) begin : g_bad_mag
      $error("largest magnitude would reach past ADJ_MIN");
   end

   logic             step;
   logic             sec_end;
   logic             at_zero;
   logic             ft_gate;
   trim_e            trim;
   logic [MIN_W-1:0] min_cnt;
   logic             minute_start;
   logic [MAG_W:0]   cal_q;

   assign step    = osc_en && !stop;
   assign ft_gate = ft_en && !alarm_flag_en && (wdog_steer || wdog_zero);

   trim_prescaler #(
      .LOW_DIV (LOW_DIV),
      .HIGH_DIV(HIGH_DIV)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .trim   (trim),
      .sec_end(sec_end),
      .at_zero(at_zero)
   );

   trim_scheduler #(
      .SEC_PER_MIN(SEC_PER_MIN),
      .CYCLE_MIN  (CYCLE_MIN),
      .ADJ_MIN    (ADJ_MIN),
      .MAG_W      (MAG_W)
   ) u_sched (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .sec_end     (sec_end),
      .at_zero     (at_zero),
      .cal_in      (cal_byte),
      .trim        (trim),
      .min_cnt     (min_cnt),
      .minute_start(minute_start),
      .cal_q       (cal_q)
   );

   ft_divider #(
      .FT_HALF(FT_HALF)
   ) u_ft (
      .clk   (clk),
      .rst_n (rst_n),
      .osc_en(osc_en),
      .stop  (stop),
      .gate  (ft_gate),
      .ft_out(ft_out)
   );

   if (TICK_REG) begin : g_tick_reg
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_q <= 1'b0;
         else        tick_q <= sec_end;
      end
      assign tick_1hz = tick_q;
   end else begin : g_tick_comb
      assign tick_1hz = sec_end;
   end
endmodule

// File: rtl/rtc_trim_checker.sv
module rtc_trim_checker #(
   parameter int MAG_W = 5,
   parameter int MIN_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stop,
   input logic             ft_en,
   input logic             alarm_flag_en,
   input logic             wdog_steer,
   input logic             wdog_zero,
   input logic             tick_1hz,
   input logic             ft_out,
   input logic             minute_start,
   input logic [MAG_W:0]   cal_q,
   input logic [MIN_W-1:0] min_cnt
);
   assert_stop_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && $past(stop)) |-> !tick_1hz);

   assert_stop_ft_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> $stable(ft_out));

   assert_ft_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop && !(ft_en && !alarm_flag_en && (wdog_steer || wdog_zero))) |=> !ft_out);

   assert_tick_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      tick_1hz |=> !tick_1hz);

   assert_cal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !minute_start |=> $stable(cal_q));

   assert_min_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (min_cnt != $past(min_cnt)) |->
         ((min_cnt == MIN_W'($past(min_cnt) + 1'b1)) || (min_cnt == '0)));
endmodule

bind rtc_trim_divider rtc_trim_checker #(
   .MAG_W(MAG_W),
   .MIN_W(MIN_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stop         (stop),
   .ft_en        (ft_en),
   .alarm_flag_en(alarm_flag_en),
   .wdog_steer   (wdog_steer),
   .wdog_zero    (wdog_zero),
   .tick_1hz     (tick_1hz),
   .ft_out       (ft_out),
   .minute_start (minute_start),
   .cal_q        (cal_q),
   .min_cnt      (min_cnt)
);

// File: tb/tb_rtc_trim_divider.sv
`timescale 1ns/1ps
module tb_rtc_trim_divider;
   localparam int LOW_DIV = 8;
   localparam int HIGH_DIV = 4;
   localparam int SPM = 3;
   localparam int FT_HALF = 4;
   localparam int NOM = LOW_DIV * HIGH_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en = 1'b1;
   logic       stop = 1'b0;
   logic [5:0] cal_byte = '0;
   logic       ft_en = 1'b0;
   logic       alarm_flag_en = 1'b0;
   logic       wdog_steer = 1'b0;
   logic       wdog_zero = 1'b0;
   logic       tick_1hz;
   logic       ft_out;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int tick_cnt = 0;
   int tick_at [0:255];
   int double_ticks = 0;
   logic tick_prev = 1'b0;
   logic half_rate = 1'b0;

   always #5 clk = ~clk;

   rtc_trim_divider #(
      .LOW_DIV(LOW_DIV), .HIGH_DIV(HIGH_DIV), .SEC_PER_MIN(SPM),
      .CYCLE_MIN(64), .ADJ_MIN(62), .MAG_W(5), .FT_HALF(FT_HALF)
   ) dut (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .cal_byte(cal_byte),
      .ft_en(ft_en), .alarm_flag_en(alarm_flag_en), .wdog_steer(wdog_steer),
      .wdog_zero(wdog_zero), .tick_1hz(tick_1hz), .ft_out(ft_out)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (tick_1hz) begin
         if (tick_cnt < 256) tick_at[tick_cnt] = cyc;
         tick_cnt = tick_cnt + 1;
         if (tick_prev) double_ticks = double_ticks + 1;
      end
      tick_prev = tick_1hz;
      osc_en = half_rate ? ~osc_en : 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int dur(input int s);
      return tick_at[s] - tick_at[s-1];
   endfunction

   task automatic wait_ticks(input int n);
      while (tick_cnt < n) @(negedge clk);
      #1;
   endtask

   task automatic do_reset(input logic [5:0] cal);
      @(negedge clk);
      rst_n = 1'b0;
      stop = 1'b0;
      half_rate = 1'b0;
      cal_byte = cal;
      ft_en = 1'b0; alarm_flag_en = 1'b0; wdog_steer = 1'b0; wdog_zero = 1'b0;
      repeat (3) @(negedge clk);
      tick_cnt = 0;
      rst_n = 1'b1;
   endtask

   // R1: quiet outputs in reset and a full first second after release
   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ft_en = 1'b1; wdog_steer = 1'b1;
      repeat (4) @(negedge clk);
      #1;
      chk(tick_1hz == 1'b0, "R1 tick in reset", tick_1hz, 0);
      chk(ft_out == 1'b0, "R1 ft_out in reset", ft_out, 0);
      ft_en = 1'b0; wdog_steer = 1'b0;
      cal_byte = '0;
      tick_cnt = 0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      #1;
      chk(tick_cnt == 0, "R1 early first tick", tick_cnt, 0);
      repeat (3) @(negedge clk);
      #1;
      chk(tick_cnt == 1, "R1 first second length", tick_cnt, 1);
   endtask

   // R2: zero magnitude keeps every second nominal
   task automatic t_nominal();
      do_reset(6'd0);
      wait_ticks(8);
      for (int s = 1; s < 8; s++) chk(dur(s) == NOM, "R2 nominal second", dur(s), NOM);
   endtask

   // R3/R5: speed-up trim of one step
   task automatic t_fast();
      do_reset(6'b100001);
      wait_ticks(8);
      chk(dur(3) == NOM - LOW_DIV, "R3 minute 1 shortened", dur(3), NOM - LOW_DIV);
      chk(dur(4) == NOM, "R5 second 1 of minute untouched", dur(4), NOM);
      chk(dur(6) == NOM, "R5 minute 2 untouched for N=1", dur(6), NOM);
   endtask

   // R4: slow-down trim of one step
   task automatic t_slow();
      do_reset(6'b000001);
      wait_ticks(8);
      chk(dur(3) == NOM + LOW_DIV / 2, "R4 minute 1 lengthened", dur(3), NOM + LOW_DIV / 2);
      chk(dur(5) == NOM, "R4 later second untouched", dur(5), NOM);
      chk(dur(6) == NOM, "R4 minute 2 untouched for N=1", dur(6), NOM);
   endtask

   // R5: full-scale trim over the whole cycle and its wrap
   task automatic t_full_cycle();
      do_reset(6'b111111);
      wait_ticks(194);
      chk(dur(3 * 61) == NOM - LOW_DIV, "R5 minute 61 adjusted", dur(3 * 61), NOM - LOW_DIV);
      chk(dur(3 * 62) == NOM, "R5 minute 62 untouched", dur(3 * 62), NOM);
      chk(dur(3 * 63) == NOM, "R5 minute 63 untouched", dur(3 * 63), NOM);
      chk(dur(3 * 64) == NOM - LOW_DIV, "R5 wrapped minute 0 adjusted", dur(3 * 64), NOM - LOW_DIV);
   endtask

   // R6: a mid-minute write waits for the next minute
   task automatic t_midchange();
      do_reset(6'd0);
      wait_ticks(3);
      repeat (5) @(negedge clk);
      cal_byte = 6'b100010;
      wait_ticks(14);
      chk(dur(3) == NOM, "R6 current minute unaffected", dur(3), NOM);
      chk(dur(6) == NOM - LOW_DIV, "R6 next minute uses new value", dur(6), NOM - LOW_DIV);
      chk(dur(9) == NOM - LOW_DIV, "R6 minute 3 adjusted for N=2", dur(9), NOM - LOW_DIV);
      chk(dur(12) == NOM, "R6 minute 4 untouched for N=2", dur(12), NOM);
   endtask

   // R7: stop freezes the second and the test output
   task automatic t_stop();
      logic held;
      do_reset(6'd0);
      ft_en = 1'b1; wdog_steer = 1'b1;
      wait_ticks(2);
      repeat (7) @(negedge clk);
      stop = 1'b1;
      #1;
      held = ft_out;
      repeat (20) begin
         @(negedge clk);
         #1;
         if (ft_out !== held) chk(1'b0, "R7 ft_out held", ft_out, held);
      end
      chk(ft_out == held, "R7 ft_out held at end", ft_out, held);
      @(negedge clk);
      stop = 1'b0;
      wait_ticks(4);
      chk(dur(2) == NOM + 21, "R7 second resumes after stop", dur(2), NOM + 21);
      chk(dur(3) == NOM, "R7 next second nominal", dur(3), NOM);
   endtask

   // R8: enable on alternate cycles
   task automatic t_half_rate();
      do_reset(6'd0);
      @(negedge clk);
      half_rate = 1'b1;
      wait_ticks(4);
      chk(dur(2) == 2 * NOM, "R8 half-rate second", dur(2), 2 * NOM);
      chk(dur(3) == 2 * NOM, "R8 half-rate second again", dur(3), 2 * NOM);
   endtask

   task automatic ft_window(input int n, output int toggles, output int bad_gap);
      logic prev;
      int last;
      toggles = 0; bad_gap = 0; last = -1;
      #1;
      prev = ft_out;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         #1;
         if (ft_out !== prev) begin
            toggles++;
            if (last >= 0 && (i - last) != FT_HALF) bad_gap++;
            last = i;
         end
         prev = ft_out;
      end
   endtask

   // R9/R10: gating of the test output
   task automatic t_ft_gate();
      int tg, bg;
      do_reset(6'd0);
      @(negedge clk);
      ft_en = 1'b1; wdog_steer = 1'b1;
      ft_window(40, tg, bg);
      chk(tg == 40 / FT_HALF, "R9 toggles with steer", tg, 40 / FT_HALF);
      chk(bg == 0, "R9 toggle spacing", bg, 0);
      @(negedge clk);
      wdog_steer = 1'b0; wdog_zero = 1'b1; ft_en = 1'b0;
      @(negedge clk);
      ft_en = 1'b1;
      ft_window(40, tg, bg);
      chk(tg == 40 / FT_HALF, "R9 toggles with watchdog zero", tg, 40 / FT_HALF);
      @(negedge clk);
      alarm_flag_en = 1'b1;
      ft_window(40, tg, bg);
      #1;
      chk(ft_out == 1'b0 && tg <= 1, "R10 alarm enable blocks", tg, 0);
      @(negedge clk);
      alarm_flag_en = 1'b0; wdog_zero = 1'b0; wdog_steer = 1'b0;
      ft_window(40, tg, bg);
      chk(ft_out == 1'b0 && tg == 0, "R10 watchdog conditions block", tg, 0);
      @(negedge clk);
      wdog_steer = 1'b1; ft_en = 1'b0;
      ft_window(40, tg, bg);
      chk(ft_out == 1'b0 && tg == 0, "R10 ft_en low blocks", tg, 0);
   endtask

   // R11: a full-scale trim leaves the test output spacing alone
   task automatic t_ft_cal();
      int tg, bg;
      do_reset(6'b011111);
      ft_en = 1'b1; wdog_steer = 1'b1;
      ft_window(200, tg, bg);
      chk(tg == 200 / FT_HALF, "R11 toggle count under trim", tg, 200 / FT_HALF);
      chk(bg == 0, "R11 spacing under trim", bg, 0);
      chk(dur(1) == NOM, "R11 run spans an adjusted minute start", dur(1), NOM);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_nominal();
      t_fast();
      t_slow();
      t_full_cycle();
      t_midchange();
      t_stop();
      t_half_rate();
      t_ft_gate();
      t_ft_cal();
      // R12: tick never stays high for two cycles
      chk(double_ticks == 0, "R12 single-cycle tick", double_ticks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule